// File: doc/BRIEF.md
# Dual-Channel Bidirectional Registered Bus Transceiver

This block joins an A bus and a B bus through two independent channels, each `CH_W` bits wide (18 by default, 36 bits in all). Each channel has one storage element per direction. The A-to-B element feeds the B port and the B-to-A element feeds the A port. On every system clock edge, each element works in one of three modes. If its latch-enable input is high, it passes the data through. If its latch-enable input is low and its own direction clock stays level, it holds the stored value. If its latch-enable input is low and the direction clock has just gone from low to high, it captures new data. The direction clocks and latch enables are sampled as plain inputs on the system clock. All outputs are registered, so any change at an input shows up at the opposite port one system clock later.

Each port is split into an input vector, an output vector and a per-bit output-enable vector, so the block fits inside FPGA fabric. Each pin also has an "external driver active" bit. When neither this block nor the external side drives a pin, a keeper holds the pin at its last driven value. The A-to-B output enable is active high. The B-to-A enable is active low. If both are active in one channel, the B port wins and the A port is released.

Top module: `dual_bus_transceiver`

## Requirements
- R1: With the A-to-B latch enable high, `b_out` of the channel equals the A pin value sampled at the previous system clock edge (transparent, one cycle of latency).
- R2: With the A-to-B latch enable low and the A-to-B clock held at a steady level, `b_out` keeps its value whatever the A data does.
- R3: With the A-to-B latch enable low, a sampled low-to-high change of the A-to-B clock captures the A data present at that edge, and `b_out` shows it one cycle later.
- R4: When the A-to-B enable is low, every bit of the channel's `b_oe` is 0 one cycle later. When it is high, and there is no contention, every bit is 1.
- R5: The B-to-A path mirrors R1 to R3 with its own latch enable and clock. Its enable is active low: when `ba_oe_n` is 0, `a_oe` is all ones one cycle later and `a_out` follows the B pins.
- R6: If the latch enable falls while the direction clock is high, the output keeps the last value that was passed through. No new data is captured until the clock goes low and then high again.
- R7: The two channels are independent. The controls and data of one channel have no effect on the other channel's outputs. Channel k occupies bits [k*CH_W +: CH_W].
- R8: A pin that no driver drives (own enable 0 and external-drive bit 0) keeps its last driven value. That includes a value this block drove itself before it released the pin.
- R9: If `ab_oe` is 1 and `ba_oe_n` is 0 in the same channel, `b_oe` is all ones and `a_oe` is all zeros one cycle later.
- R10: A synchronous active-high reset clears both storage elements, the keepers and the output enables to 0. After reset, a direction clock that is already high does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_oe | input | NCH | A-to-B output enable per channel, active high |
| ab_le | input | NCH | A-to-B latch enable per channel |
| ab_clk | input | NCH | A-to-B capture clock per channel (sampled) |
| ba_oe_n | input | NCH | B-to-A output enable per channel, active low |
| ba_le | input | NCH | B-to-A latch enable per channel |
| ba_clk | input | NCH | B-to-A capture clock per channel (sampled) |
| a_in | input | NCH*CH_W | Value driven onto the A pins from outside |
| a_in_en | input | NCH*CH_W | Per-bit external drive active on the A pins |
| a_out | output | NCH*CH_W | Value this block drives onto the A pins |
| a_oe | output | NCH*CH_W | Per-bit drive enable for the A pins |
| b_in | input | NCH*CH_W | Value driven onto the B pins from outside |
| b_in_en | input | NCH*CH_W | Per-bit external drive active on the B pins |
| b_out | output | NCH*CH_W | Value this block drives onto the B pins |
| b_oe | output | NCH*CH_W | Per-bit drive enable for the B pins |

## Verification
The main target is the latch-enable falling while the direction clock is still high. A design that treats the level clock as an edge, or re-arms on the falling enable, would capture new data there and break R6. The bench also releases pins that the block itself was driving and then passes them back through the other direction. A keeper that only remembers external values would hand over stale or zero data there. The remaining sweeps cover the active-low enable, the contention priority and cross-channel leakage. These expose a wrong polarity, both ports driving at once, or slice indexing that lets one channel's controls move the other's bits.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_EDGE = 2'd2
  } store_mode_t;

  function automatic store_mode_t pick_mode(input logic le, input logic dclk_now,
                                            input logic dclk_prev);
    if (le) return MODE_PASS;
    else if (dclk_now && !dclk_prev) return MODE_EDGE;
    else return MODE_HOLD;
  endfunction
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         dclk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import xcvr_pkg::*;

  logic        dclk_prev;
  store_mode_t mode;

  assign mode = pick_mode(le, dclk, dclk_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= '0;
      dclk_prev <= 1'b1;
    end else begin
      dclk_prev <= dclk;
      if (mode != MODE_HOLD) q <= d;
    end
  end

  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(d)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!le && !$rose(dclk)) |=> $stable(q));

  assert_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (!le && $rose(dclk) && !$past(rst)) |=> (q == $past(d)));
endmodule

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] own_en,
  input  logic [W-1:0] own_val,
  input  logic [W-1:0] ext_en,
  input  logic [W-1:0] ext_val,
  output logic [W-1:0] pin
);
  logic [W-1:0] held;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (own_en[i])      pin[i] = own_val[i];
      else if (ext_en[i]) pin[i] = ext_val[i];
      else                pin[i] = held[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= pin;
  end

  assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (((own_en | ext_en) == '0) && !$past(rst)) |-> (pin == $past(pin)));
endmodule

// File: rtl/xcvr_channel.sv
module xcvr_channel #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_in_en,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_in_en,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic         b_drv_q, a_drv_q;
  logic [W-1:0] a_pin, b_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_drv_q <= 1'b0;
      a_drv_q <= 1'b0;
    end else begin
      b_drv_q <= ab_oe;
      a_drv_q <= !ba_oe_n && !ab_oe;
    end
  end

  assign b_oe = {W{b_drv_q}};
  assign a_oe = {W{a_drv_q}};

  bus_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst(rst), .own_en(a_oe), .own_val(a_out),
    .ext_en(a_in_en), .ext_val(a_in), .pin(a_pin)
  );

  bus_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst(rst), .own_en(b_oe), .own_val(b_out),
    .ext_en(b_in_en), .ext_val(b_in), .pin(b_pin)
  );

  xcvr_store #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .le(ab_le), .dclk(ab_clk), .d(a_pin), .q(b_out)
  );

  xcvr_store #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .le(ba_le), .dclk(ba_clk), .d(b_pin), .q(a_out)
  );

  assert_b_off_R4: assert property (@(posedge clk) disable iff (rst)
    !ab_oe |=> (b_oe == '0));

  assert_a_on_R5: assert property (@(posedge clk) disable iff (rst)
    (!ba_oe_n && !ab_oe) |=> (a_oe == '1));

  assert_b_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (ab_oe && !ba_oe_n) |=> ((b_oe == '1) && (a_oe == '0)));
endmodule

// File: rtl/dual_bus_transceiver.sv
module dual_bus_transceiver #(
  parameter int CH_W = 18,
  parameter int NCH  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      ab_oe,
  input  logic [NCH-1:0]      ab_le,
  input  logic [NCH-1:0]      ab_clk,
  input  logic [NCH-1:0]      ba_oe_n,
  input  logic [NCH-1:0]      ba_le,
  input  logic [NCH-1:0]      ba_clk,
  input  logic [NCH*CH_W-1:0] a_in,
  input  logic [NCH*CH_W-1:0] a_in_en,
  output logic [NCH*CH_W-1:0] a_out,
  output logic [NCH*CH_W-1:0] a_oe,
  input  logic [NCH*CH_W-1:0] b_in,
  input  logic [NCH*CH_W-1:0] b_in_en,
  output logic [NCH*CH_W-1:0] b_out,
  output logic [NCH*CH_W-1:0] b_oe
);
  localparam int TOTAL_W = NCH * CH_W;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    xcvr_channel #(.W(CH_W)) u_ch (
      .clk(clk), .rst(rst),
      .ab_oe(ab_oe[k]), .ab_le(ab_le[k]), .ab_clk(ab_clk[k]),
      .ba_oe_n(ba_oe_n[k]), .ba_le(ba_le[k]), .ba_clk(ba_clk[k]),
      .a_in(a_in[k*CH_W +: CH_W]), .a_in_en(a_in_en[k*CH_W +: CH_W]),
      .a_out(a_out[k*CH_W +: CH_W]), .a_oe(a_oe[k*CH_W +: CH_W]),
      .b_in(b_in[k*CH_W +: CH_W]), .b_in_en(b_in_en[k*CH_W +: CH_W]),
      .b_out(b_out[k*CH_W +: CH_W]), .b_oe(b_oe[k*CH_W +: CH_W])
    );
  end

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> ((b_out == '0) && (a_out == '0) && (a_oe == '0) && (b_oe == '0)));

  initial assert (TOTAL_W > 0);
endmodule

// File: tb/dual_bus_transceiver_test.sv
module dual_bus_transceiver_test;
  localparam int CH_W = 18;
  localparam int NCH  = 2;
  localparam int TW   = NCH * CH_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ab_oe = '0, ab_le = '0, ab_clk = '0;
  logic [NCH-1:0] ba_oe_n = '1, ba_le = '0, ba_clk = '0;
  logic [TW-1:0] a_in = '0, a_in_en = '1, b_in = '0, b_in_en = '1;
  logic [TW-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dual_bus_transceiver #(.CH_W(CH_W), .NCH(NCH)) uut (
    .clk(clk), .rst(rst),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .a_in(a_in), .a_in_en(a_in_en), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_in_en(b_in_en), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [TW-1:0] pat(input int i);
    logic [63:0] v;
    v = (64'(i) * 64'h9E3779B97F4A7C15) ^ (64'(i) << 21) ^ 64'h5A5A;
    return v[TW-1:0];
  endfunction

  logic [TW-1:0] keep, lo_mask;

  initial begin
    lo_mask = {{CH_W{1'b0}}, {CH_W{1'b1}}};
    ab_clk = '1;
    step(3);
    // R10: reset state
    chk("R10 b_out", b_out, '0);
    chk("R10 a_out", a_out, '0);
    chk("R10 oe", a_oe | b_oe, '0);
    rst = 1'b0;
    a_in = pat(99);
    step(2);
    // R10: clock already high at reset release is not an edge
    chk("R10 no edge", b_out, '0);

    // R4: disabled B port
    chk("R4 b_oe off", b_oe, '0);

    // R1: transparent sweep
    ab_oe = '1; ab_le = '1;
    for (int i = 0; i < 24; i++) begin
      a_in = pat(i);
      step(1);
      chk("R1 pass", b_out, pat(i));
      chk("R4 b_oe on", b_oe, '1);
    end

    // R6: latch enable falls with clock high, then data changes
    keep = pat(23);
    ab_le = '0;
    a_in = pat(50);
    step(3);
    chk("R6 held", b_out, keep);
    ab_clk = '0; a_in = pat(51);
    step(1);
    chk("R6 low phase", b_out, keep);
    ab_clk = '1; a_in = pat(52);
    step(1);
    chk("R6 fresh edge", b_out, pat(52));

    // R2 and R3: clocked sweep with holding in between
    for (int i = 0; i < 12; i++) begin
      ab_clk = '0; a_in = pat(100 + i);
      step(2);
      chk("R2 level low", b_out, (i == 0) ? pat(52) : pat(200 + i - 1));
      a_in = pat(200 + i); ab_clk = '1;
      step(1);
      chk("R3 edge", b_out, pat(200 + i));
      a_in = pat(300 + i);
      step(2);
      chk("R2 level high", b_out, pat(200 + i));
    end

    // R4: enable off
    ab_oe = '0;
    step(1);
    chk("R4 off again", b_oe, '0);

    // R5: B-to-A path, active-low enable
    ba_oe_n = '0; ba_le = '1;
    for (int i = 0; i < 8; i++) begin
      b_in = pat(400 + i);
      step(1);
      chk("R5 pass", a_out, pat(400 + i));
      chk("R5 a_oe", a_oe, '1);
    end
    ba_le = '0; ba_clk = '0; b_in = pat(500);
    step(2);
    chk("R5 hold", a_out, pat(407));
    ba_clk = '1; b_in = pat(501);
    step(1);
    chk("R5 edge", a_out, pat(501));

    // R9: contention, B port wins
    ab_oe = '1;
    step(1);
    chk("R9 b_oe", b_oe, '1);
    chk("R9 a_oe", a_oe, '0);
    ab_oe = '0;
    step(1);
    chk("R9 a_oe back", a_oe, '1);

    // R8: own driven value kept after release, passed back to B
    a_in_en = '0; a_in = pat(600);
    step(1);
    ba_oe_n = '1;
    step(2);
    chk("R8 a released", a_oe, '0);
    ab_le = '1; ab_oe = '1;
    step(2);
    chk("R8 own value kept", b_out, pat(501));
    // R8: external value kept after external release
    a_in_en = '1; a_in = pat(601);
    step(2);
    a_in_en = '0; a_in = pat(602);
    step(3);
    chk("R8 ext value kept", b_out, pat(601));
    a_in_en = '1;

    // R7: channel independence
    ab_le = 2'b01; ab_clk = 2'b00;
    a_in = pat(700);
    step(2);
    keep = b_out;
    for (int i = 0; i < 6; i++) begin
      a_in = pat(710 + i);
      ab_clk[1] = ~ab_clk[1] & 1'b0;
      ba_oe_n[1] = i[0];
      step(1);
      chk("R7 ch0 follows", b_out & lo_mask, pat(710 + i) & lo_mask);
      chk("R7 ch1 steady", b_out & ~lo_mask, keep & ~lo_mask);
    end
    ab_le = 2'b10; ba_oe_n = '1;
    a_in = pat(800);
    step(1);
    chk("R7 ch1 follows", b_out & ~lo_mask, pat(800) & ~lo_mask);
    chk("R7 ch0 steady", b_out & lo_mask, pat(715) & lo_mask);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule